// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses for one eight-beat memory burst. A single-cycle start strobe loads a column address and a burst kind. From the next cycle on, the block presents one column address per clock for eight clocks. Only the three low column bits change from beat to beat. The bits above them are frozen at the values loaded with the burst. A valid flag marks each beat, and a last flag marks the eighth.

The three low bits follow one of two orders. In sequential order each beat is one more than the previous beat, modulo 8, so the sequence wraps inside the aligned block of eight. In interleaved order, beat k carries the start offset XOR k. A new start strobe always wins: it ends any burst in progress and starts the new one in the following cycle. A strobe on the last beat therefore chains two bursts with no gap.

The controller is a two-state machine. ST_IDLE presents nothing. ST_BURST presents one beat per cycle. Its transitions are:
- LAUNCH: ST_IDLE to ST_BURST on a start strobe.
- HOLD: ST_IDLE stays in ST_IDLE with no strobe.
- STEP: ST_BURST stays in ST_BURST and advances the beat when neither the last beat nor a strobe is present.
- RESTART: ST_BURST stays in ST_BURST and reloads on a strobe, on any beat including the last.
- FINISH: ST_BURST returns to ST_IDLE after the last beat when no strobe is present.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and right after it, valid_o and last_o are 0.
- R2: In the cycle after a start strobe, valid_o is 1 and col_o equals the col_i value sampled with the strobe (beat 0).
- R3: With kind_i = 0 (sequential) at the strobe, the low three bits of col_o on beat k equal (start offset + k) mod 8.
- R4: With kind_i = 1 (interleaved) at the strobe, the low three bits of col_o on beat k equal start offset XOR k.
- R5: A burst that no new strobe interrupts presents exactly eight consecutive valid beats. last_o is 1 only on the eighth beat, and valid_o falls in the following cycle.
- R6: In either order, each of the eight offsets 0 to 7 appears exactly once in a complete burst, for every start offset.
- R7: Bits col_o[COL_W-1:3] hold the values sampled with the strobe for the whole burst. Changes on col_i and kind_i between strobes have no effect on col_o.
- R8: A strobe during a burst abandons it, and the next cycle presents beat 0 of the new burst.
- R9: A strobe on the last beat gives beat 0 of the next burst in the very next cycle, so valid_o stays 1 with no gap.
- R10: With no strobe, an idle block keeps valid_o at 0 whatever col_i and kind_i do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a new burst |
| kind_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| col_i | input | COL_W | Starting column address; bits [2:0] are the start offset |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present on col_o |
| last_o | output | 1 | The current beat is the eighth |

## Verification
On every cycle, the assertions check that beat 0 follows a strobe with the sampled address. They also check that the upper column bits stay frozen, that each beat moves one step in sequential order and matches the XOR rule in interleaved order, and that last_o falls on the eighth beat only. They also check that an idle block does not start without a strobe. The bench's scenarios alone show the full coverage of each order: every start offset in both orders, with one offset seen once per burst. Only the scenarios also show that inputs changed mid-burst do not disturb it, and what happens when a restart lands mid-burst or on the last beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int BEAT_W = 3;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic {
        BK_SEQ = 1'b0,
        BK_ILV = 1'b1
    } burst_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_col_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic beat_last_i,
    output logic load_o,
    output logic adv_o,
    output logic busy_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_BURST;
                else         state_d = ST_IDLE;
            end
            ST_BURST: begin
                if (start_i)          state_d = ST_BURST;
                else if (beat_last_i) state_d = ST_IDLE;
                else                  state_d = ST_BURST;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = 1'b0;
        adv_o  = 1'b0;
        busy_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_o = start_i;
            end
            ST_BURST: begin
                busy_o = 1'b1;
                load_o = start_i;
                adv_o  = !start_i && !beat_last_i;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    output logic [CNT_W-1:0] beat_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

    logic [CNT_W-1:0] beat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      beat_q <= '0;
        else if (load_i) beat_q <= '0;
        else if (adv_i)  beat_q <= beat_q + 1'b1;
    end

    assign beat_o = beat_q;
    assign last_o = (beat_q == LAST_BEAT);

endmodule

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [COL_W-1:0] col_i,
    input  logic             kind_i,
    output logic [COL_W-1:0] col_o,
    output burst_kind_e      kind_o
);

    logic [COL_W-1:0] col_q;
    burst_kind_e      kind_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            kind_q <= BK_SEQ;
        end else if (load_i) begin
            col_q  <= col_i;
            kind_q <= burst_kind_e'(kind_i);
        end
    end

    assign col_o  = col_q;
    assign kind_o = kind_q;

endmodule

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
    import burst_col_pkg::*;
#(
    parameter int OFF_W = 3
) (
    input  logic [OFF_W-1:0] base_i,
    input  logic [OFF_W-1:0] beat_i,
    input  burst_kind_e      kind_i,
    output logic [OFF_W-1:0] off_o
);

    logic [OFF_W-1:0] seq_off;
    logic [OFF_W-1:0] ilv_off;

    // Sequential order wraps inside the aligned block by modular addition.
    assign seq_off = base_i + beat_i;

    // Interleaved order flips each offset bit where the beat count has a 1.
    for (genvar b = 0; b < OFF_W; b++) begin : g_ilv_bit
        assign ilv_off[b] = base_i[b] ^ beat_i[b];
    end

    always_comb begin
        unique case (kind_i)
            BK_SEQ:  off_o = seq_off;
            BK_ILV:  off_o = ilv_off;
            default: off_o = seq_off;
        endcase
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             kind_i,
    input  logic [COL_W-1:0] col_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);

    localparam int UP_W = COL_W - BEAT_W;

    logic             load;
    logic             adv;
    logic             busy;
    logic [BEAT_W-1:0] beat;
    logic             beat_last;
    logic [COL_W-1:0] ctx_col;
    burst_kind_e      ctx_kind;
    logic [BEAT_W-1:0] off;

    burst_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .beat_last_i (beat_last),
        .load_o      (load),
        .adv_o       (adv),
        .busy_o      (busy)
    );

    burst_beat_cnt #(.CNT_W(BEAT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (adv),
        .beat_o (beat),
        .last_o (beat_last)
    );

    burst_ctx_reg #(.COL_W(COL_W)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .col_i  (col_i),
        .kind_i (kind_i),
        .col_o  (ctx_col),
        .kind_o (ctx_kind)
    );

    burst_offset_gen #(.OFF_W(BEAT_W)) u_off (
        .base_i (ctx_col[BEAT_W-1:0]),
        .beat_i (beat),
        .kind_i (ctx_kind),
        .off_o  (off)
    );

    always_comb begin
        col_o   = {ctx_col[COL_W-1 -: UP_W], off};
        valid_o = busy;
        last_o  = busy && beat_last;
    end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             kind_i,
    input logic [COL_W-1:0] col_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);

    logic       ck_kind;
    logic [2:0] ck_off;
    logic [2:0] ck_k;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_kind <= 1'b0;
            ck_off  <= '0;
            ck_k    <= '0;
        end else if (start_i) begin
            ck_kind <= kind_i;
            ck_off  <= col_i[2:0];
            ck_k    <= '0;
        end else if (valid_o) begin
            ck_k <= ck_k + 1'b1;
        end
    end

    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!valid_o && !last_o);
        end
    end

    // R2, R7, R8: the strobe is followed by beat 0 of the sampled address
    p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(col_i)));

    p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i) |=>
            (valid_o && col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])));

    p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i && !ck_kind) |=>
            (col_o[2:0] == $past(col_o[2:0]) + 3'd1));

    p_ilv_rule_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ck_kind) |-> ((col_o[2:0] ^ ck_off) == ck_k));

    p_last_eighth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (last_o == (ck_k == 3'd7)));

    p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_end_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .kind_i  (kind_i),
    .col_i   (col_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/burst_col_seq_bench.sv
module burst_col_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;
    localparam int UP_W       = COL_W - 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             kind_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;
    logic [7:0] seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .kind_i  (kind_i),
        .col_i   (col_i),
        .col_o   (col_o),
        .valid_o (valid_o),
        .last_o  (last_o)
    );

    function automatic logic [2:0] exp_off(input logic [2:0] s, input logic m, input int k);
        logic [2:0] kk;
        kk = 3'(k);
        return m ? (s ^ kk) : (s + kk);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; the burst's beat 0 is on the outputs on return.
    task automatic start_burst(input logic [2:0] s, input logic m, input logic [UP_W-1:0] up);
        start_i = 1'b1;
        kind_i  = m;
        col_i   = {up, s};
        @(negedge clk);
        start_i = 1'b0;
        col_i   = ~col_i;
        kind_i  = ~m;
    endtask

    // Checks beats kfrom..kto, stepping one cycle between them.
    task automatic run_beats(input logic [2:0] s, input logic m, input logic [UP_W-1:0] up,
                             input int kfrom, input int kto);
        for (int k = kfrom; k <= kto; k++) begin
            logic [2:0] e;
            e = exp_off(s, m, k);
            seen[col_o[2:0]] = 1'b1;
            check(valid_o === 1'b1, "R5 valid during burst", valid_o, 1);
            if (k == 0)
                check(col_o === {up, e}, "R2 beat0 address", col_o, {up, e});
            else if (m)
                check(col_o[2:0] === e, "R4 interleaved offset", col_o[2:0], e);
            else
                check(col_o[2:0] === e, "R3 sequential offset", col_o[2:0], e);
            check(col_o[COL_W-1:3] === up, "R7 upper bits held", col_o[COL_W-1:3], up);
            check(last_o === (k == 7), "R5 last on eighth beat", last_o, (k == 7));
            if (k != kto) @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(valid_o === 1'b0 && last_o === 1'b0, "R1 quiet in reset", {valid_o, last_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o === 1'b0 && last_o === 1'b0, "R1 quiet after reset", {valid_o, last_o}, 0);

        // R10: idle inputs wiggle without a strobe
        for (int i = 0; i < 4; i++) begin
            col_i  = COL_W'(i * 37 + 5);
            kind_i = i[0];
            @(negedge clk);
            check(valid_o === 1'b0, "R10 idle stays idle", valid_o, 0);
        end

        // Sweep every start offset in both orders
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                logic [UP_W-1:0] up;
                up   = UP_W'((m * 8 + s) * 5 + 3);
                seen = '0;
                start_burst(3'(s), m[0], up);
                run_beats(3'(s), m[0], up, 0, 7);
                check(seen === 8'hFF, "R6 each offset once", seen, 8'hFF);
                @(negedge clk);
                check(valid_o === 1'b0 && last_o === 1'b0, "R5 valid falls after burst",
                      {valid_o, last_o}, 0);
            end
        end

        // R8: restart in the middle of a burst
        start_burst(3'd2, 1'b0, 7'h11);
        run_beats(3'd2, 1'b0, 7'h11, 0, 3);
        @(negedge clk);
        start_burst(3'd6, 1'b1, 7'h55);
        check(col_o === {7'h55, 3'd6}, "R8 restart gives new beat0", col_o, {7'h55, 3'd6});
        seen = '0;
        run_beats(3'd6, 1'b1, 7'h55, 0, 7);
        check(seen === 8'hFF, "R8 restarted burst complete", seen, 8'hFF);
        @(negedge clk);
        check(valid_o === 1'b0, "R8 restarted burst ends", valid_o, 0);

        // R9: chain on the last beat with no gap
        start_burst(3'd1, 1'b1, 7'h2A);
        run_beats(3'd1, 1'b1, 7'h2A, 0, 7);
        start_burst(3'd7, 1'b0, 7'h7F);
        check(valid_o === 1'b1 && col_o === {7'h7F, 3'd7}, "R9 chained beat0 no gap",
              col_o, {7'h7F, 3'd7});
        run_beats(3'd7, 1'b0, 7'h7F, 0, 7);
        @(negedge clk);
        check(valid_o === 1'b0, "R9 chained burst ends", valid_o, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule